// File: doc/BRIEF.md
# Serial PLL Configuration Register File

This block takes 22-bit programming words from a slow three-wire serial port: a shift clock, a data line and a latch strobe. It decodes each word into the control fields of a dual-loop frequency synthesizer, which has a high-frequency (HF) loop and a low-frequency (LF) loop. Words are shifted in most significant bit first. When the latch strobe rises, the two leading bits of the word choose which of four register sets takes the other twenty bits: the reference set or the counter set, of either loop.

The three serial inputs are synchronized into the system clock domain, and their edges are detected there. All stored fields are flops in that domain, so the divider and charge-pump logic around the block reads stable, clock-aligned values. The block also derives, for each loop, a signal that puts that loop's phase-detector output into high impedance. Power-down does not block programming.

Top module: `pll_cfg_regfile`

## Requirements
- R1: After a synchronous reset, both loops hold reference divide 3, main count 3 and swallow 0. Their phase-sense, charge-pump, lock-detect, frequency-out and prescaler bits are 0. Their power-down bits are 1, so both high-impedance outputs are 1.
- R2: Word bits 1–2 (the first two shifted) choose the destination: 00 is the LF reference set, 01 the LF counter set, 10 the HF reference set and 11 the HF counter set. A latch changes only the addressed set.
- R3: Reference word layout: bits 3–17 are the divide value, with bit 3 as its MSB. Bit 18 is phase sense, bit 19 charge-pump high current, bit 20 tri-state, bit 21 lock-detect select and bit 22 frequency-out select.
- R4: Counter word layout: bits 3–9 are the swallow count (bit 3 MSB) and bits 10–20 the main count (bit 10 MSB). Bit 21 is the prescaler select and bit 22 is power-down.
- R5: A reference divide value below 3 is stored as 3. The values 3 through 32767 are stored unchanged.
- R6: A main count below 3 is stored as 3. The values 3 through 2047 are stored unchanged.
- R7: A data bit is shifted in on each rising edge of the serial clock, but only while the latch input is low. Serial clock edges while the latch input is high have no effect.
- R8: Stored fields change only on a rising edge of the latch input. Shifting alone leaves every output unchanged.
- R9: A loop whose power-down bit is 1 still accepts and stores new words of either format.
- R10: A loop's high-impedance output is 1 when its own power-down bit is 1, or when the tri-state bit of either loop's reference set is 1.
- R11: If more than 22 bits are shifted before a latch, only the last 22 bits count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial shift clock |
| ser_data | input | 1 | Serial data, MSB first |
| ser_le | input | 1 | Latch strobe; low while shifting, rising edge stores |
| hf_ref_div | output | 15 | HF reference divide value |
| hf_phase_pos | output | 1 | HF phase sense (1 = positive VCO slope) |
| hf_cp_hi | output | 1 | HF charge-pump high current |
| hf_ld_sel | output | 1 | HF lock-detect select |
| hf_fo_sel | output | 1 | HF frequency-out select |
| hf_swallow | output | 7 | HF swallow count |
| hf_main | output | 11 | HF main count |
| hf_presc_hi | output | 1 | HF prescaler select |
| hf_pwr_down | output | 1 | HF power-down |
| hf_pd_hiz | output | 1 | HF phase-detector output high impedance |
| lf_ref_div | output | 15 | LF reference divide value |
| lf_phase_pos | output | 1 | LF phase sense |
| lf_cp_hi | output | 1 | LF charge-pump high current |
| lf_ld_sel | output | 1 | LF lock-detect select |
| lf_fo_sel | output | 1 | LF frequency-out select |
| lf_swallow | output | 7 | LF swallow count |
| lf_main | output | 11 | LF main count |
| lf_presc_hi | output | 1 | LF prescaler select |
| lf_pwr_down | output | 1 | LF power-down |
| lf_pd_hiz | output | 1 | LF phase-detector output high impedance |

## Verification
All four control codes are exercised. After each latch, the sets that were not addressed are checked as well, which separates correct routing from a swapped or shared write enable. The field patterns use distinct asymmetric values, so a reversed bit order or an off-by-one field boundary shows up as a wrong value. Divide values of 0, 1, 3 and the maximum separate correct saturation from a missing clamp or an over-eager one. Three further cases separate shifting from latching: a word that is shifted but never latched, serial clocks sent while the latch input is high, and an overlong word.

// File: rtl/pll_cfg_pkg.sv
package pll_cfg_pkg;
  localparam int WORD_W = 22;
  localparam int REF_W  = 15;
  localparam int SWAL_W = 7;
  localparam int MAIN_W = 11;
  localparam int MIN_DIV = 3;

  // destination code carried in the first two bits of a word
  typedef enum logic [1:0] {
    SEL_LF_REF = 2'b00,
    SEL_LF_CNT = 2'b01,
    SEL_HF_REF = 2'b10,
    SEL_HF_CNT = 2'b11
  } dest_e;

  // payload layouts; first member sits at the payload MSB
  typedef struct packed {
    logic [REF_W-1:0] ref_div;
    logic             phase_pos;
    logic             cp_hi;
    logic             tristate;
    logic             ld_sel;
    logic             fo_sel;
  } ref_word_t;

  typedef struct packed {
    logic [SWAL_W-1:0] swallow;
    logic [MAIN_W-1:0] main_cnt;
    logic              presc_hi;
    logic              pwr_down;
  } cnt_word_t;
endpackage

// File: rtl/pll_cfg_ser_front.sv
module pll_cfg_ser_front #(
  parameter int WORD_W      = 22,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ser_clk,
  input  logic              ser_data,
  input  logic              ser_le,
  output logic [WORD_W-1:0] word,
  output logic              latch_pulse
);
  localparam int TOP = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] s_clk, s_dat, s_le;
  logic clk_d, le_d;
  logic clk_rise, le_rise;

  always_ff @(posedge clk) begin
    if (rst) begin
      s_clk <= '0;
      s_dat <= '0;
      s_le  <= '0;
      clk_d <= 1'b0;
      le_d  <= 1'b0;
    end else begin
      s_clk <= {s_clk[SYNC_STAGES-2:0], ser_clk};
      s_dat <= {s_dat[SYNC_STAGES-2:0], ser_data};
      s_le  <= {s_le[SYNC_STAGES-2:0], ser_le};
      clk_d <= s_clk[TOP];
      le_d  <= s_le[TOP];
    end
  end

  assign clk_rise = s_clk[TOP] & ~clk_d;
  assign le_rise  = s_le[TOP] & ~le_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      word        <= '0;
      latch_pulse <= 1'b0;
    end else begin
      latch_pulse <= le_rise;
      if (clk_rise && !s_le[TOP])
        word <= {word[WORD_W-2:0], s_dat[TOP]};
    end
  end
endmodule

// File: rtl/pll_cfg_decode.sv
module pll_cfg_decode
  import pll_cfg_pkg::*;
#(
  parameter int WORD_W = 22
) (
  input  logic [WORD_W-1:0] word,
  output dest_e             dest,
  output ref_word_t         ref_w,
  output cnt_word_t         cnt_w
);
  localparam int PAY_W = WORD_W - 2;

  ref_word_t ref_raw;
  cnt_word_t cnt_raw;

  assign dest    = dest_e'(word[WORD_W-1 -: 2]);
  assign ref_raw = ref_word_t'(word[PAY_W-1:0]);
  assign cnt_raw = cnt_word_t'(word[PAY_W-1:0]);

  always_comb begin
    ref_w = ref_raw;
    cnt_w = cnt_raw;
    if (ref_raw.ref_div < REF_W'(MIN_DIV))
      ref_w.ref_div = REF_W'(MIN_DIV);
    if (cnt_raw.main_cnt < MAIN_W'(MIN_DIV))
      cnt_w.main_cnt = MAIN_W'(MIN_DIV);
  end
endmodule

// File: rtl/pll_cfg_loop_regs.sv
module pll_cfg_loop_regs
  import pll_cfg_pkg::*;
#(
  parameter bit IS_HF = 1'b0
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      latch_pulse,
  input  dest_e     dest,
  input  ref_word_t ref_w,
  input  cnt_word_t cnt_w,
  output ref_word_t ref_q,
  output cnt_word_t cnt_q
);
  localparam dest_e REF_SEL = IS_HF ? SEL_HF_REF : SEL_LF_REF;
  localparam dest_e CNT_SEL = IS_HF ? SEL_HF_CNT : SEL_LF_CNT;

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_q         <= '0;
      ref_q.ref_div <= REF_W'(MIN_DIV);
      cnt_q          <= '0;
      cnt_q.main_cnt <= MAIN_W'(MIN_DIV);
      cnt_q.pwr_down <= 1'b1;
    end else if (latch_pulse) begin
      if (dest == REF_SEL) ref_q <= ref_w;
      if (dest == CNT_SEL) cnt_q <= cnt_w;
    end
  end
endmodule

// File: rtl/pll_cfg_regfile.sv
module pll_cfg_regfile
  import pll_cfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ser_clk,
  input  logic              ser_data,
  input  logic              ser_le,
  output logic [REF_W-1:0]  hf_ref_div,
  output logic              hf_phase_pos,
  output logic              hf_cp_hi,
  output logic              hf_ld_sel,
  output logic              hf_fo_sel,
  output logic [SWAL_W-1:0] hf_swallow,
  output logic [MAIN_W-1:0] hf_main,
  output logic              hf_presc_hi,
  output logic              hf_pwr_down,
  output logic              hf_pd_hiz,
  output logic [REF_W-1:0]  lf_ref_div,
  output logic              lf_phase_pos,
  output logic              lf_cp_hi,
  output logic              lf_ld_sel,
  output logic              lf_fo_sel,
  output logic [SWAL_W-1:0] lf_swallow,
  output logic [MAIN_W-1:0] lf_main,
  output logic              lf_presc_hi,
  output logic              lf_pwr_down,
  output logic              lf_pd_hiz
);
  localparam int N_LOOPS = 2; // index 0 = LF, 1 = HF

  logic [WORD_W-1:0] word;
  logic              latch_pulse;
  dest_e             dest;
  ref_word_t         ref_w;
  cnt_word_t         cnt_w;
  ref_word_t         ref_q [N_LOOPS];
  cnt_word_t         cnt_q [N_LOOPS];
  logic              any_tristate;

  pll_cfg_ser_front #(.WORD_W(WORD_W), .SYNC_STAGES(SYNC_STAGES)) u_front (
    .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_data(ser_data),
    .ser_le(ser_le), .word(word), .latch_pulse(latch_pulse)
  );

  pll_cfg_decode #(.WORD_W(WORD_W)) u_dec (
    .word(word), .dest(dest), .ref_w(ref_w), .cnt_w(cnt_w)
  );

  for (genvar g = 0; g < N_LOOPS; g++) begin : g_loop
    pll_cfg_loop_regs #(.IS_HF(g == 1)) u_regs (
      .clk(clk), .rst(rst), .latch_pulse(latch_pulse), .dest(dest),
      .ref_w(ref_w), .cnt_w(cnt_w), .ref_q(ref_q[g]), .cnt_q(cnt_q[g])
    );
  end

  assign any_tristate = ref_q[0].tristate | ref_q[1].tristate;

  assign hf_ref_div   = ref_q[1].ref_div;
  assign hf_phase_pos = ref_q[1].phase_pos;
  assign hf_cp_hi     = ref_q[1].cp_hi;
  assign hf_ld_sel    = ref_q[1].ld_sel;
  assign hf_fo_sel    = ref_q[1].fo_sel;
  assign hf_swallow   = cnt_q[1].swallow;
  assign hf_main      = cnt_q[1].main_cnt;
  assign hf_presc_hi  = cnt_q[1].presc_hi;
  assign hf_pwr_down  = cnt_q[1].pwr_down;
  assign hf_pd_hiz    = any_tristate | cnt_q[1].pwr_down;

  assign lf_ref_div   = ref_q[0].ref_div;
  assign lf_phase_pos = ref_q[0].phase_pos;
  assign lf_cp_hi     = ref_q[0].cp_hi;
  assign lf_ld_sel    = ref_q[0].ld_sel;
  assign lf_fo_sel    = ref_q[0].fo_sel;
  assign lf_swallow   = cnt_q[0].swallow;
  assign lf_main      = cnt_q[0].main_cnt;
  assign lf_presc_hi  = cnt_q[0].presc_hi;
  assign lf_pwr_down  = cnt_q[0].pwr_down;
  assign lf_pd_hiz    = any_tristate | cnt_q[0].pwr_down;
endmodule

// File: rtl/pll_cfg_checker.sv
module pll_cfg_checker
  import pll_cfg_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              latch_pulse,
  input logic [REF_W-1:0]  hf_ref_div,
  input logic [REF_W-1:0]  lf_ref_div,
  input logic [MAIN_W-1:0] hf_main,
  input logic [MAIN_W-1:0] lf_main,
  input logic              hf_pwr_down,
  input logic              lf_pwr_down
);
  // R1: reset loads the documented defaults
  a_r1_reset_defaults: assert property (@(posedge clk)
    rst |=> (hf_ref_div == REF_W'(MIN_DIV)) && (lf_ref_div == REF_W'(MIN_DIV))
         && (hf_main == MAIN_W'(MIN_DIV)) && (lf_main == MAIN_W'(MIN_DIV))
         && hf_pwr_down && lf_pwr_down);

  // R2: a latch touches at most one destination set
  a_r2_single_dest: assert property (@(posedge clk) disable iff (rst)
    latch_pulse |=> $countones({!$stable(hf_ref_div), !$stable(lf_ref_div),
                                !$stable(hf_main), !$stable(lf_main)}) <= 1);

  // R5: stored reference divide never below the floor
  a_r5_ref_floor: assert property (@(posedge clk) disable iff (rst)
    (hf_ref_div >= REF_W'(MIN_DIV)) && (lf_ref_div >= REF_W'(MIN_DIV)));

  // R6: stored main count never below the floor
  a_r6_main_floor: assert property (@(posedge clk) disable iff (rst)
    (hf_main >= MAIN_W'(MIN_DIV)) && (lf_main >= MAIN_W'(MIN_DIV)));

  // R8: without a latch event the stored fields hold
  a_r8_hold_without_latch: assert property (@(posedge clk) disable iff (rst)
    !latch_pulse |=> $stable(hf_ref_div) && $stable(lf_ref_div)
                  && $stable(hf_main) && $stable(lf_main)
                  && $stable(hf_pwr_down) && $stable(lf_pwr_down));
endmodule

bind pll_cfg_regfile pll_cfg_checker u_chk (
  .clk(clk), .rst(rst), .latch_pulse(latch_pulse),
  .hf_ref_div(hf_ref_div), .lf_ref_div(lf_ref_div),
  .hf_main(hf_main), .lf_main(lf_main),
  .hf_pwr_down(hf_pwr_down), .lf_pwr_down(lf_pwr_down)
);

// File: tb/pll_cfg_regfile_test.sv
module pll_cfg_regfile_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ser_clk = 1'b0, ser_data = 1'b0, ser_le = 1'b0;
  logic [14:0] hf_ref_div, lf_ref_div;
  logic hf_phase_pos, hf_cp_hi, hf_ld_sel, hf_fo_sel;
  logic lf_phase_pos, lf_cp_hi, lf_ld_sel, lf_fo_sel;
  logic [6:0] hf_swallow, lf_swallow;
  logic [10:0] hf_main, lf_main;
  logic hf_presc_hi, hf_pwr_down, hf_pd_hiz;
  logic lf_presc_hi, lf_pwr_down, lf_pd_hiz;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  pll_cfg_regfile uut (
    .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_data(ser_data), .ser_le(ser_le),
    .hf_ref_div(hf_ref_div), .hf_phase_pos(hf_phase_pos), .hf_cp_hi(hf_cp_hi),
    .hf_ld_sel(hf_ld_sel), .hf_fo_sel(hf_fo_sel), .hf_swallow(hf_swallow),
    .hf_main(hf_main), .hf_presc_hi(hf_presc_hi), .hf_pwr_down(hf_pwr_down),
    .hf_pd_hiz(hf_pd_hiz),
    .lf_ref_div(lf_ref_div), .lf_phase_pos(lf_phase_pos), .lf_cp_hi(lf_cp_hi),
    .lf_ld_sel(lf_ld_sel), .lf_fo_sel(lf_fo_sel), .lf_swallow(lf_swallow),
    .lf_main(lf_main), .lf_presc_hi(lf_presc_hi), .lf_pwr_down(lf_pwr_down),
    .lf_pd_hiz(lf_pd_hiz)
  );

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // shift the low n bits of w, MSB first
  task automatic shift_bits(logic [31:0] w, int n);
    for (int i = n - 1; i >= 0; i--) begin
      ser_data = w[i];
      wait_n(4);
      ser_clk = 1'b1;
      wait_n(4);
      ser_clk = 1'b0;
    end
    wait_n(4);
  endtask

  task automatic latch();
    ser_le = 1'b1;
    wait_n(8);
    ser_le = 1'b0;
    wait_n(8);
  endtask

  function automatic logic [21:0] mk_ref(logic [1:0] sel, logic [14:0] r,
      logic ph, logic cp, logic ts, logic ld, logic fo);
    return {sel, r, ph, cp, ts, ld, fo};
  endfunction

  function automatic logic [21:0] mk_cnt(logic [1:0] sel, logic [6:0] a,
      logic [10:0] b, logic pre, logic pd);
    return {sel, a, b, pre, pd};
  endfunction

  task automatic send(logic [21:0] w);
    shift_bits({10'd0, w}, 22);
    latch();
  endtask

  task automatic t_reset();
    check("R1", "hf_ref", hf_ref_div, 3);
    check("R1", "lf_ref", lf_ref_div, 3);
    check("R1", "hf_main", hf_main, 3);
    check("R1", "lf_swallow", lf_swallow, 0);
    check("R1", "flags", {hf_phase_pos, hf_cp_hi, hf_ld_sel, hf_fo_sel, hf_presc_hi,
                          lf_phase_pos, lf_cp_hi, lf_ld_sel, lf_fo_sel, lf_presc_hi}, 0);
    check("R1", "pd", {hf_pwr_down, lf_pwr_down, hf_pd_hiz, lf_pd_hiz}, 4'hF);
  endtask

  task automatic t_route_fields();
    send(mk_ref(2'b10, 15'h4A5B, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0));
    check("R3", "hf_ref", hf_ref_div, 15'h4A5B);
    check("R3", "hf_bits", {hf_phase_pos, hf_cp_hi, hf_ld_sel, hf_fo_sel}, 4'b1010);
    check("R2", "lf_ref untouched", lf_ref_div, 3);
    check("R2", "hf_main untouched", hf_main, 3);
    send(mk_ref(2'b00, 15'd1234, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1));
    check("R3", "lf_ref", lf_ref_div, 1234);
    check("R3", "lf_bits", {lf_phase_pos, lf_cp_hi, lf_ld_sel, lf_fo_sel}, 4'b0101);
    check("R2", "hf_ref kept", hf_ref_div, 15'h4A5B);
    send(mk_cnt(2'b01, 7'd13, 11'd1029, 1'b1, 1'b0));
    check("R4", "lf_swallow", lf_swallow, 13);
    check("R4", "lf_main", lf_main, 1029);
    check("R4", "lf_pre_pd", {lf_presc_hi, lf_pwr_down}, 2'b10);
    check("R2", "hf_swallow untouched", hf_swallow, 0);
    check("R2", "lf_ref kept", lf_ref_div, 1234);
    send(mk_cnt(2'b11, 7'd100, 11'd6, 1'b0, 1'b0));
    check("R4", "hf_swallow", hf_swallow, 100);
    check("R4", "hf_main", hf_main, 6);
    check("R4", "hf_pd", hf_pwr_down, 0);
    check("R2", "lf_main kept", lf_main, 1029);
  endtask

  task automatic t_saturate();
    send(mk_ref(2'b10, 15'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0));
    check("R5", "ref 1 -> 3", hf_ref_div, 3);
    send(mk_ref(2'b10, 15'd32767, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0));
    check("R5", "ref max", hf_ref_div, 32767);
    send(mk_ref(2'b00, 15'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0));
    check("R5", "ref 0 -> 3", lf_ref_div, 3);
    send(mk_ref(2'b00, 15'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0));
    check("R5", "ref 3", lf_ref_div, 3);
    send(mk_cnt(2'b11, 7'd0, 11'd0, 1'b0, 1'b0));
    check("R6", "main 0 -> 3", hf_main, 3);
    send(mk_cnt(2'b01, 7'd0, 11'd2, 1'b0, 1'b0));
    check("R6", "main 2 -> 3", lf_main, 3);
    send(mk_cnt(2'b11, 7'd0, 11'd2047, 1'b0, 1'b0));
    check("R6", "main max", hf_main, 2047);
  endtask

  task automatic t_shift_no_latch();
    send(mk_ref(2'b10, 15'd100, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0));
    shift_bits({10'd0, mk_ref(2'b10, 15'd555, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0)}, 22);
    wait_n(8);
    check("R8", "no latch, no change", hf_ref_div, 100);
    latch();
    check("R8", "after latch", hf_ref_div, 555);
  endtask

  task automatic t_le_high_clocks();
    send(mk_ref(2'b10, 15'd200, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0));
    ser_le = 1'b1;
    wait_n(8);
    shift_bits({10'd0, mk_ref(2'b00, 15'd999, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0)}, 22);
    ser_le = 1'b0;
    wait_n(8);
    latch();
    check("R7", "hf_ref relatched", hf_ref_div, 200);
    check("R7", "lf_ref untouched", lf_ref_div, 3);
  endtask

  task automatic t_powerdown_hiz();
    send(mk_cnt(2'b11, 7'd5, 11'd77, 1'b1, 1'b1));
    check("R9", "hf_pd set", hf_pwr_down, 1);
    check("R10", "hf hiz by pd", hf_pd_hiz, 1);
    send(mk_cnt(2'b11, 7'd9, 11'd88, 1'b0, 1'b1));
    check("R9", "write while down", {hf_swallow, hf_main}, {7'd9, 11'd88});
    send(mk_ref(2'b10, 15'd300, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0));
    check("R9", "ref write while down", hf_ref_div, 300);
    send(mk_cnt(2'b01, 7'd1, 11'd50, 1'b0, 1'b0));
    check("R10", "lf not hiz", lf_pd_hiz, 0);
    send(mk_ref(2'b00, 15'd40, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0));
    check("R10", "ts forces both", {hf_pd_hiz, lf_pd_hiz}, 2'b11);
    send(mk_ref(2'b00, 15'd40, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0));
    send(mk_cnt(2'b11, 7'd9, 11'd88, 1'b0, 1'b0));
    check("R10", "both released", {hf_pd_hiz, lf_pd_hiz}, 2'b00);
  endtask

  task automatic t_long_word();
    shift_bits({7'd0, 3'b111, mk_ref(2'b00, 15'd4321, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0)}, 25);
    latch();
    check("R11", "last 22 bits", lf_ref_div, 4321);
    check("R11", "hf_ref kept", hf_ref_div, 300);
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wait_n(5);
    rst = 1'b0;
    wait_n(2);
    t_reset();
    t_route_fields();
    t_saturate();
    t_shift_no_latch();
    t_le_high_clocks();
    t_powerdown_hiz();
    t_long_word();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule